// File: doc/BRIEF.md
# Multi-Wide Register Rename Stage

This block maps the architectural register numbers of up to four instructions per cycle onto physical tags. Each slot carries two source register numbers and an optional destination. Source tags come from an internal alias table. Each slot that writes a register gets a fresh tag from an external free-list interface. Dependencies between members of the same group are resolved inside the cycle. A later slot that reads a register written by an earlier slot gets that slot's new tag. Two slots that write the same register each get their own tag.

For every writing slot the block also reports the tag that the destination held just before that slot. The retire logic uses this value to return the tag to the free list. The free list presents up to WIDTH candidate tags in order, together with a count of how many are usable. The block replies with the number it consumed. When the group needs more tags than are available, nothing in the group is renamed and the table stays as it was.

Top module: `rn_stage`

## Requirements
- R1: After reset, every architectural register r maps to tag r. A source register r that no earlier group member writes yields tag r. An asserted rst_ni restores this identity map at any time.
- R2: A slot requests a tag when its slot_vld_i bit is 1, its dst_we_i bit is 1 and its dst_i is nonzero. The k-th requesting slot, counted from slot 0 upward, receives fl_tag_i[k] on pdst_o. On fire, fl_pop_o equals the number of requesting slots.
- R3: A slot that does not request a tag consumes none, and its pdst_o and pold_o are 0. This covers dst_we_i low and a destination of register 0. Its dst_i value has no effect on the table.
- R4: A source equal to the destination of an earlier requesting slot in the same group yields that slot's new tag, not the table value.
- R5: When several earlier slots write the same register, a source takes the tag of the nearest earlier writer.
- R6: A source equal to its own slot's destination yields the mapping held before that slot, never the slot's own new tag.
- R7: When slots write the same register, each receives a distinct tag. The pold_o of a later writer is the tag given to the nearest earlier writer in the group.
- R8: After a fired group, the table holds for each register the tag of the youngest slot in the group that wrote it.
- R9: Source register 0 always yields tag 0.
- R10: If the number of requesting slots exceeds fl_avail_i while any slot is valid, then stall_o=1, fire_o=0 and fl_pop_o=0, and the table is left unchanged.
- R11: A slot with slot_vld_i low yields 0 on all its tag outputs. It requests no tag and does not update the table. With no slot valid, both fire_o and stall_o are 0.
- R12: For a requesting slot with no earlier same-register writer, pold_o is the table's mapping of its destination before the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slot_vld_i | input | WIDTH | Slot holds an instruction |
| src1_i | input | WIDTH x AW | First source register per slot |
| src2_i | input | WIDTH x AW | Second source register per slot |
| dst_we_i | input | WIDTH | Slot writes a destination |
| dst_i | input | WIDTH x AW | Destination register per slot |
| fl_tag_i | input | WIDTH x TW | Candidate free tags, in consumption order |
| fl_avail_i | input | CW | Number of usable candidate tags |
| fire_o | output | 1 | Group renamed this cycle |
| stall_o | output | 1 | Group held for lack of tags |
| fl_pop_o | output | CW | Tags consumed this cycle |
| psrc1_o | output | WIDTH x TW | Renamed first source |
| psrc2_o | output | WIDTH x TW | Renamed second source |
| pdst_o | output | WIDTH x TW | New destination tag |
| pold_o | output | WIDTH x TW | Prior mapping of the destination, for reclaim |

## Verification
The main function is driven with four kinds of group: fully independent groups, read-after-write chains, groups where every slot writes the same register, and groups with a mix of valid and writing slots. The independent groups separate free-list ordering from table reads. The chains show whether forwarding picks the nearest earlier writer rather than the table or the first writer. The same-register groups expose write-back priority and the reported prior mappings. Follow-up groups read back the registers touched by stalled, invalid and non-writing slots, which proves those slots left the table alone. Register 0, exact and short tag supply, and an idle group are each tried on their own.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int DEF_WIDTH = 4;
  localparam int DEF_ARCH  = 32;
  localparam int DEF_TAGS  = 64;
endpackage

// File: rtl/rn_alloc.sv
module rn_alloc #(
  parameter int WIDTH = 4,
  parameter int TW    = 6,
  parameter int CW    = 3
) (
  input  logic [WIDTH-1:0]         req_i,
  input  logic [WIDTH-1:0][TW-1:0] fl_tag_i,
  input  logic [CW-1:0]            fl_avail_i,
  output logic [WIDTH-1:0][TW-1:0] new_tag_o,
  output logic [CW-1:0]            need_o,
  output logic                     ok_o
);
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < WIDTH; i++) begin
      new_tag_o[i] = '0;
      if (req_i[i]) begin
        new_tag_o[i] = fl_tag_i[cnt[IW-1:0]];
        cnt = cnt + CW'(1);
      end
    end
    need_o = cnt;
    ok_o   = (cnt <= fl_avail_i);
  end
endmodule

// File: rtl/rn_rat.sv
module rn_rat #(
  parameter int NUM_ARCH = 32,
  parameter int TW       = 6,
  parameter int WIDTH    = 4,
  parameter int NRD      = 12,
  localparam int AW      = $clog2(NUM_ARCH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NRD-1:0][AW-1:0]   rd_addr_i,
  output logic [NRD-1:0][TW-1:0]   rd_tag_o,
  input  logic [WIDTH-1:0]         we_i,
  input  logic [WIDTH-1:0][AW-1:0] wa_i,
  input  logic [WIDTH-1:0][TW-1:0] wd_i
);
  logic [TW-1:0] tbl [NUM_ARCH];

  // later slots are younger: last write in the loop wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_ARCH; r++) tbl[r] <= TW'(r);
    end else begin
      for (int i = 0; i < WIDTH; i++)
        if (we_i[i] && (wa_i[i] != '0)) tbl[wa_i[i]] <= wd_i[i];
    end
  end

  generate
    for (genvar k = 0; k < NRD; k++) begin : g_rd
      assign rd_tag_o[k] = (rd_addr_i[k] == '0) ? '0 : tbl[rd_addr_i[k]];
    end
  endgenerate
endmodule

// File: rtl/rn_src_fwd.sv
module rn_src_fwd #(
  parameter int WIDTH = 4,
  parameter int AW    = 5,
  parameter int TW    = 6,
  parameter int SLOT  = 0
) (
  input  logic [AW-1:0]            reg_i,
  input  logic [TW-1:0]            tbl_tag_i,
  input  logic [WIDTH-1:0]         req_i,
  input  logic [WIDTH-1:0][AW-1:0] dst_i,
  input  logic [WIDTH-1:0][TW-1:0] new_tag_i,
  output logic [TW-1:0]            tag_o
);
  // scan older slots upward so the nearest earlier writer overrides
  always_comb begin
    tag_o = tbl_tag_i;
    for (int j = 0; j < WIDTH; j++)
      if ((j < SLOT) && req_i[j] && (dst_i[j] == reg_i)) tag_o = new_tag_i[j];
    if (reg_i == '0) tag_o = '0;
  end
endmodule

// File: rtl/rn_stage.sv
module rn_stage #(
  parameter int  WIDTH    = rn_pkg::DEF_WIDTH,
  parameter int  NUM_ARCH = rn_pkg::DEF_ARCH,
  parameter int  NUM_TAG  = rn_pkg::DEF_TAGS,
  localparam int AW       = $clog2(NUM_ARCH),
  localparam int TW       = $clog2(NUM_TAG),
  localparam int CW       = $clog2(WIDTH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [WIDTH-1:0]         slot_vld_i,
  input  logic [WIDTH-1:0][AW-1:0] src1_i,
  input  logic [WIDTH-1:0][AW-1:0] src2_i,
  input  logic [WIDTH-1:0]         dst_we_i,
  input  logic [WIDTH-1:0][AW-1:0] dst_i,
  input  logic [WIDTH-1:0][TW-1:0] fl_tag_i,
  input  logic [CW-1:0]            fl_avail_i,
  output logic                     fire_o,
  output logic                     stall_o,
  output logic [CW-1:0]            fl_pop_o,
  output logic [WIDTH-1:0][TW-1:0] psrc1_o,
  output logic [WIDTH-1:0][TW-1:0] psrc2_o,
  output logic [WIDTH-1:0][TW-1:0] pdst_o,
  output logic [WIDTH-1:0][TW-1:0] pold_o
);
  localparam int NRD = 3 * WIDTH;

  logic [WIDTH-1:0]          req;
  logic [WIDTH-1:0][TW-1:0]  new_tag;
  logic [CW-1:0]             need;
  logic                      ok;
  logic                      any_vld;
  logic [NRD-1:0][AW-1:0]    rd_addr;
  logic [NRD-1:0][TW-1:0]    rd_tag;
  logic [WIDTH-1:0]          rat_we;
  logic [WIDTH-1:0][TW-1:0]  fwd1, fwd2, fwd_old;

  always_comb begin
    for (int i = 0; i < WIDTH; i++)
      req[i] = slot_vld_i[i] && dst_we_i[i] && (dst_i[i] != '0);
  end

  assign any_vld  = |slot_vld_i;
  assign fire_o   = any_vld && ok;
  assign stall_o  = any_vld && !ok;
  assign fl_pop_o = fire_o ? need : '0;
  assign rat_we   = fire_o ? req : '0;

  rn_alloc #(.WIDTH(WIDTH), .TW(TW), .CW(CW)) i_alloc (
    .req_i      (req),
    .fl_tag_i   (fl_tag_i),
    .fl_avail_i (fl_avail_i),
    .new_tag_o  (new_tag),
    .need_o     (need),
    .ok_o       (ok)
  );

  rn_rat #(.NUM_ARCH(NUM_ARCH), .TW(TW), .WIDTH(WIDTH), .NRD(NRD)) i_rat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (rd_addr),
    .rd_tag_o  (rd_tag),
    .we_i      (rat_we),
    .wa_i      (dst_i),
    .wd_i      (new_tag)
  );

  generate
    for (genvar s = 0; s < WIDTH; s++) begin : g_slot
      assign rd_addr[3*s]   = src1_i[s];
      assign rd_addr[3*s+1] = src2_i[s];
      assign rd_addr[3*s+2] = dst_i[s];

      rn_src_fwd #(.WIDTH(WIDTH), .AW(AW), .TW(TW), .SLOT(s)) i_fwd1 (
        .reg_i (src1_i[s]), .tbl_tag_i (rd_tag[3*s]), .req_i (req),
        .dst_i (dst_i), .new_tag_i (new_tag), .tag_o (fwd1[s])
      );
      rn_src_fwd #(.WIDTH(WIDTH), .AW(AW), .TW(TW), .SLOT(s)) i_fwd2 (
        .reg_i (src2_i[s]), .tbl_tag_i (rd_tag[3*s+1]), .req_i (req),
        .dst_i (dst_i), .new_tag_i (new_tag), .tag_o (fwd2[s])
      );
      // prior mapping of the destination sees older same-group writers too
      rn_src_fwd #(.WIDTH(WIDTH), .AW(AW), .TW(TW), .SLOT(s)) i_fwd_old (
        .reg_i (dst_i[s]), .tbl_tag_i (rd_tag[3*s+2]), .req_i (req),
        .dst_i (dst_i), .new_tag_i (new_tag), .tag_o (fwd_old[s])
      );

      assign psrc1_o[s] = slot_vld_i[s] ? fwd1[s] : '0;
      assign psrc2_o[s] = slot_vld_i[s] ? fwd2[s] : '0;
      assign pdst_o[s]  = req[s] ? new_tag[s] : '0;
      assign pold_o[s]  = req[s] ? fwd_old[s] : '0;
    end
  endgenerate
endmodule

// File: rtl/rn_stage_chk.sv
module rn_stage_chk #(
  parameter int  WIDTH    = 4,
  parameter int  NUM_ARCH = 32,
  parameter int  NUM_TAG  = 64,
  localparam int AW       = $clog2(NUM_ARCH),
  localparam int TW       = $clog2(NUM_TAG),
  localparam int CW       = $clog2(WIDTH + 1)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [WIDTH-1:0]         slot_vld_i,
  input logic [WIDTH-1:0][AW-1:0] src1_i,
  input logic [WIDTH-1:0][AW-1:0] src2_i,
  input logic [WIDTH-1:0]         dst_we_i,
  input logic [WIDTH-1:0][AW-1:0] dst_i,
  input logic [WIDTH-1:0][TW-1:0] fl_tag_i,
  input logic [CW-1:0]            fl_avail_i,
  input logic                     fire_o,
  input logic                     stall_o,
  input logic [CW-1:0]            fl_pop_o,
  input logic [WIDTH-1:0][TW-1:0] psrc1_o,
  input logic [WIDTH-1:0][TW-1:0] psrc2_o,
  input logic [WIDTH-1:0][TW-1:0] pdst_o,
  input logic [WIDTH-1:0][TW-1:0] pold_o
);
  logic [WIDTH-1:0] want;
  always_comb begin
    for (int i = 0; i < WIDTH; i++)
      want[i] = slot_vld_i[i] && dst_we_i[i] && (dst_i[i] != '0);
  end

  a_r10_stall_no_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (fl_pop_o == '0) && !fire_o);

  a_r2_pop_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> (fl_pop_o == CW'($countones(want))) && (fl_pop_o <= fl_avail_i));

  a_r2_first_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && want[0]) |-> (pdst_o[0] == fl_tag_i[0]));

  a_r8_youngest_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && want[WIDTH-1]) |=>
      (!(slot_vld_i[0] && (src1_i[0] == $past(dst_i[WIDTH-1])))
       || (psrc1_o[0] == $past(pdst_o[WIDTH-1]))));

  generate
    for (genvar s = 0; s < WIDTH; s++) begin : g_s
      a_r9_zero_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_vld_i[s] && (src1_i[s] == '0)) |-> (psrc1_o[s] == '0));
      if (s > 0) begin : g_pair
        a_r4_adjacent_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (want[s-1] && slot_vld_i[s] && (src2_i[s] == dst_i[s-1]))
            |-> (psrc2_o[s] == pdst_o[s-1]));
        a_r7_waw_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (want[s-1] && want[s] && (dst_i[s] == dst_i[s-1]))
            |-> (pold_o[s] == pdst_o[s-1]));
      end
    end
  endgenerate
endmodule

bind rn_stage rn_stage_chk #(.WIDTH(WIDTH), .NUM_ARCH(NUM_ARCH), .NUM_TAG(NUM_TAG))
  i_rn_stage_chk (.*);

// File: tb/test_rn_stage.sv
`timescale 1ns/1ps
module test_rn_stage;
  localparam int W = 4;

  typedef struct packed {
    logic [0:3]      vld;
    logic [0:3]      dwe;
    logic [0:3][4:0] s1;
    logic [0:3][4:0] s2;
    logic [0:3][4:0] d;
    logic [2:0]      av;
    logic            st;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'b1111, 4'b1111, '{5'd5,5'd6,5'd7,5'd8},     '{5'd9,5'd10,5'd11,5'd12}, '{5'd1,5'd2,5'd3,5'd4},     3'd4, 1'b0},
    '{4'b1111, 4'b1111, '{5'd2,5'd1,5'd2,5'd3},     '{5'd0,5'd4,5'd1,5'd1},    '{5'd1,5'd2,5'd3,5'd1},     3'd4, 1'b0},
    '{4'b1111, 4'b1110, '{5'd7,5'd7,5'd7,5'd7},     '{5'd8,5'd8,5'd8,5'd8},    '{5'd7,5'd7,5'd8,5'd0},     3'd3, 1'b0},
    '{4'b1111, 4'b1111, '{5'd9,5'd9,5'd9,5'd9},     '{5'd0,5'd0,5'd0,5'd0},    '{5'd9,5'd9,5'd9,5'd9},     3'd4, 1'b0},
    '{4'b1100, 4'b1100, '{5'd10,5'd10,5'd0,5'd0},   '{5'd11,5'd3,5'd0,5'd0},   '{5'd10,5'd11,5'd0,5'd0},   3'd2, 1'b0},
    '{4'b1110, 4'b1110, '{5'd12,5'd13,5'd14,5'd0},  '{5'd0,5'd0,5'd0,5'd0},    '{5'd12,5'd13,5'd14,5'd0},  3'd2, 1'b1},
    '{4'b1111, 4'b0000, '{5'd12,5'd13,5'd14,5'd9},  '{5'd1,5'd2,5'd3,5'd4},    '{5'd12,5'd13,5'd14,5'd15}, 3'd0, 1'b0},
    '{4'b1111, 4'b1111, '{5'd0,5'd0,5'd0,5'd5},     '{5'd5,5'd0,5'd0,5'd0},    '{5'd0,5'd0,5'd5,5'd0},     3'd1, 1'b0},
    '{4'b1001, 4'b1111, '{5'd17,5'd0,5'd0,5'd18},   '{5'd16,5'd0,5'd0,5'd17},  '{5'd16,5'd17,5'd18,5'd19}, 3'd2, 1'b0},
    '{4'b1111, 4'b0000, '{5'd16,5'd17,5'd18,5'd19}, '{5'd9,5'd7,5'd1,5'd5},    '{5'd0,5'd0,5'd0,5'd0},     3'd0, 1'b0},
    '{4'b1111, 4'b1111, '{5'd20,5'd21,5'd22,5'd23}, '{5'd0,5'd0,5'd0,5'd0},    '{5'd20,5'd21,5'd22,5'd23}, 3'd3, 1'b1},
    '{4'b0000, 4'b1111, '{5'd0,5'd0,5'd0,5'd0},     '{5'd0,5'd0,5'd0,5'd0},    '{5'd24,5'd25,5'd26,5'd27}, 3'd0, 1'b0},
    '{4'b1111, 4'b0000, '{5'd20,5'd21,5'd22,5'd23}, '{5'd24,5'd25,5'd26,5'd27},'{5'd0,5'd0,5'd0,5'd0},     3'd0, 1'b0}
  };

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [W-1:0]          slot_vld_i = '0;
  logic [W-1:0][4:0]     src1_i = '0, src2_i = '0, dst_i = '0;
  logic [W-1:0]          dst_we_i = '0;
  logic [W-1:0][5:0]     fl_tag_i = '0;
  logic [2:0]            fl_avail_i = '0;
  logic                  fire_o, stall_o;
  logic [2:0]            fl_pop_o;
  logic [W-1:0][5:0]     psrc1_o, psrc2_o, pdst_o, pold_o;

  rn_stage i_rn_stage (.*);

  always #2.5 clk_i = ~clk_i;

  int n_run = 0, n_fail = 0;
  logic [5:0] rat_m [32];
  int nf = 0;
  logic [W-1:0]      e_req;
  logic [W-1:0][5:0] e_new;
  int e_need;
  logic e_fire, e_stall;

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < 32; r++) rat_m[r] = 6'(r);
  endtask

  function automatic logic [5:0] resolve(int slot, logic [4:0] a);
    logic [5:0] t;
    if (a == 0) return 6'd0;
    t = rat_m[a];
    for (int j = 0; j < slot; j++) if (e_req[j] && dst_i[j] == a) t = e_new[j];
    return t;
  endfunction

  task automatic apply(vec_t v);
    for (int i = 0; i < W; i++) begin
      slot_vld_i[i] = v.vld[i];
      dst_we_i[i]   = v.dwe[i];
      src1_i[i]     = v.s1[i];
      src2_i[i]     = v.s2[i];
      dst_i[i]      = v.d[i];
      fl_tag_i[i]   = 6'(32 + ((nf + i) % 32));
    end
    fl_avail_i = v.av;
  endtask

  // expected values from the requirements, then compare; update model on fire
  task automatic check_group(int idx);
    int rank = 0;
    string sfx;
    e_need = 0;
    for (int i = 0; i < W; i++) begin
      e_req[i] = slot_vld_i[i] && dst_we_i[i] && dst_i[i] != 0;
      e_new[i] = 6'd0;
      if (e_req[i]) begin
        e_new[i] = 6'(32 + ((nf + rank) % 32));
        rank++;
      end
    end
    e_need  = rank;
    e_fire  = (|slot_vld_i) && (e_need <= int'(fl_avail_i));
    e_stall = (|slot_vld_i) && !(e_need <= int'(fl_avail_i));
    sfx = $sformatf(" v%0d", idx);
    chk({"R10 stall", sfx}, stall_o, e_stall);
    chk({"R11 fire", sfx}, fire_o, e_fire);
    chk({"R2 pop", sfx}, fl_pop_o, e_fire ? e_need : 0);
    for (int i = 0; i < W; i++) begin
      chk({"R4 R5 R6 R9 src1", sfx}, psrc1_o[i], slot_vld_i[i] ? resolve(i, src1_i[i]) : 0);
      chk({"R4 R5 R9 src2", sfx}, psrc2_o[i], slot_vld_i[i] ? resolve(i, src2_i[i]) : 0);
      chk({"R2 R3 pdst", sfx}, pdst_o[i], e_new[i]);
      chk({"R7 R12 pold", sfx}, pold_o[i], e_req[i] ? resolve(i, dst_i[i]) : 0);
    end
    if (e_fire) begin
      for (int i = 0; i < W; i++) if (e_req[i]) rat_m[dst_i[i]] = e_new[i]; // R8
      nf += e_need;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk_i);
    // R1: identity map while in reset
    slot_vld_i = 4'b0001; src1_i[0] = 5'd5; src2_i[0] = 5'd31;
    #1;
    chk("R1 reset src1", psrc1_o[0], 5);
    chk("R1 reset src2", psrc2_o[0], 31);
    chk("R1 reset pop", fl_pop_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    slot_vld_i = '0;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i);
      apply(VECS[v]);
      #1;
      chk($sformatf("R10 table stall flag v%0d", v), stall_o, VECS[v].st);
      check_group(v);
    end
    // R10: zero supply with one writer
    @(negedge clk_i);
    apply('{4'b1000, 4'b1000, '{5'd3,5'd0,5'd0,5'd0}, '0, '{5'd3,5'd0,5'd0,5'd0}, 3'd0, 1'b1});
    #1;
    check_group(100);
    // R1: reset mid-run restores identity
    @(negedge clk_i);
    rst_ni = 1'b0;
    model_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply('{4'b1111, 4'b0000, '{5'd1,5'd9,5'd20,5'd12}, '{5'd16,5'd7,5'd3,5'd31}, '0, 3'd0, 1'b0});
    #1;
    chk("R1 post reset src1 slot0", psrc1_o[0], 1);
    chk("R1 post reset src1 slot1", psrc1_o[1], 9);
    chk("R1 post reset src2 slot0", psrc2_o[0], 16);
    check_group(101);
    @(negedge clk_i);
    slot_vld_i = '0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule